// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Bridge Channel

This block is one audio DMA bridge unit with two independent engines. The transmit engine reads 32-bit words from memory and pushes them into an audio serial port FIFO. The receive engine pops words from the serial port FIFO and writes them to memory. Each engine walks a buffer made of a start address and a byte count. It moves one word for each granted memory request and pulses an event at the half-way point and at the end of every pass. With reload enabled, the engine then starts again from the start address, so the buffer behaves as a ring.

Software drives the unit through a small word-addressed register file. The register file holds the two start addresses, the two byte counts, one shared control word and two read-only progress counters. The control word carries, for each direction, an enable bit, a self-clearing force-stop bit, a reload bit and a 2-bit alignment mode that reorders bytes within each word on its way through.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset every register reads 0, no memory request is raised, no serial push or pop occurs and all event lines are low.
- R2: Register offsets are 0x00 transmit start address, 0x04 receive start address, 0x08 transmit byte count, 0x0C receive byte count, 0x10 control, 0x14 transmit progress, 0x18 receive progress. Read data appears on the cycle after the read strobe. Addresses and counts read back with bits 1:0 cleared, and counts also have bits above 25 cleared (largest count 0x03FFFFFC). An access whose address bits 1:0 are not zero is ignored.
- R3: The control word holds the transmit fields at bit 0 enable, bit 1 force stop, bit 2 reload and bits 9:8 mode. The receive fields are the same at bits 16, 17, 18 and 25:24. The force-stop bits always read back as 0.
- R4: An enabled engine raises its memory request while its serial side is ready (transmit FIFO not full, receive FIFO not empty). The request address is start address plus progress. Each grant moves one word and adds 4 to progress. Transmit data is pushed to the serial port on the cycle after the grant. A receive pop happens in the grant cycle, with the write data taken from the popped word.
- R5: Alignment mode 0 (none) and the unused code 3 pass words unchanged. Mode 1 (4-byte) reverses the byte order. Mode 2 (two-word) swaps the 16-bit halves.
- R6: The half event (event bit 0 for transmit, bit 2 for receive) is a one-cycle pulse. It comes on the cycle after the grant that brings progress to half the count, rounded down to a multiple of 4.
- R7: The full event (event bit 1 for transmit, bit 3 for receive) is a one-cycle pulse on the cycle after the grant that completes the count. Progress returns to 0. Without reload the enable bit clears and requests stop. With reload the engine continues from the start address.
- R8: Writing a 1 to a force-stop bit clears that direction's enable bit and progress on the next cycle. Writing the control word with the enable bit at 0 and the stop bit at 0 pauses the engine and keeps its progress, and setting enable again resumes from there.
- R9: An engine whose byte count is below 8 raises no request even when enabled.
- R10: Writes to a direction's start address or byte count are ignored while that direction is enabled. A byte count write while disabled resets that direction's progress to 0.
- R11: When a force stop and a grant fall in the same cycle, the stop wins. The word is not counted, no event is raised and no serial push or pop happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| txm_req | output | 1 | Transmit memory read request |
| txm_addr | output | AW | Transmit memory read address |
| txm_gnt | input | 1 | Transmit memory grant, read data valid with it |
| txm_rdata | input | 32 | Transmit memory read data |
| txs_data | output | 32 | Word pushed to the serial transmit FIFO |
| txs_valid | output | 1 | Push strobe for the serial transmit FIFO |
| txs_full | input | 1 | Serial transmit FIFO full |
| rxs_data | input | 32 | Head word of the serial receive FIFO |
| rxs_empty | input | 1 | Serial receive FIFO empty |
| rxs_pop | output | 1 | Pop strobe for the serial receive FIFO |
| rxm_req | output | 1 | Receive memory write request |
| rxm_addr | output | AW | Receive memory write address |
| rxm_wdata | output | 32 | Receive memory write data |
| rxm_gnt | input | 1 | Receive memory write grant |
| evt | output | 4 | Event pulses: transmit half, transmit full, receive half, receive full |

## Verification
A software force stop and the memory grant that finishes a pass can fall in the same clock. That cycle decides whether the word counts, whether a full event fires and whether the enable is cleared by the pass end or by the stop. The bench lines up the stop write with the second grant of an 8-byte transmit pass, with the grant held open. It then judges from the ports alone: exactly one pushed word, one half event and no full event, and the enable and progress both read back as 0. A second overlap, a register write landing on the grant that pauses a receive transfer, is judged by the progress value read back after the pause.

// File: rtl/ardma_pkg.sv
package ardma_pkg;

  // word index of each register (byte address bits 4:2)
  localparam logic [2:0] IX_TX_BASE = 3'd0;
  localparam logic [2:0] IX_RX_BASE = 3'd1;
  localparam logic [2:0] IX_TX_CNT  = 3'd2;
  localparam logic [2:0] IX_RX_CNT  = 3'd3;
  localparam logic [2:0] IX_CTRL    = 3'd4;
  localparam logic [2:0] IX_TX_PROG = 3'd5;
  localparam logic [2:0] IX_RX_PROG = 3'd6;

  // per-direction field positions inside the control word
  localparam int DIR_STRIDE = 16;
  localparam int B_EN       = 0;
  localparam int B_STOP     = 1;
  localparam int B_RELOAD   = 2;
  localparam int B_MODE     = 8;

  localparam int MIN_BYTES  = 8;

  typedef enum logic [1:0] {
    ALN_NONE  = 2'd0,
    ALN_BYTE4 = 2'd1,
    ALN_WORD2 = 2'd2,
    ALN_RSVD  = 2'd3
  } align_e;

  typedef struct packed {
    logic   en;
    logic   reload;
    align_e mode;
  } dir_ctl_t;

  function automatic logic [31:0] align_word(input align_e m, input logic [31:0] w);
    case (m)
      ALN_BYTE4: align_word = {w[7:0], w[15:8], w[23:16], w[31:24]};
      ALN_WORD2: align_word = {w[15:0], w[31:16]};
      default:   align_word = w;
    endcase
  endfunction

endpackage

// File: rtl/ardma_regs.sv
module ardma_regs
  import ardma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 26
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic           rd,
  input  logic [4:0]     addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  input  logic [CW-1:0]  prog  [2],
  input  logic           done  [2],
  output dir_ctl_t       ctl   [2],
  output logic           stop  [2],
  output logic           clr   [2],
  output logic [AW-1:0]  base  [2],
  output logic [CW-1:0]  cnt   [2]
);

  logic        aligned;
  logic [2:0]  idx;
  logic        wr_ok;
  logic [31:0] ctrl_rd;

  assign aligned = (addr[1:0] == 2'b00);
  assign idx     = addr[4:2];
  assign wr_ok   = wr && aligned;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    localparam logic [2:0] IX_B = 3'(d);
    localparam logic [2:0] IX_C = 3'(2 + d);
    localparam int         OFS  = d * DIR_STRIDE;

    logic ctl_wr;
    logic base_wr;
    logic cnt_wr;

    assign ctl_wr  = wr_ok && (idx == IX_CTRL);
    assign base_wr = wr_ok && (idx == IX_B) && !ctl[d].en;
    assign cnt_wr  = wr_ok && (idx == IX_C) && !ctl[d].en;

    assign stop[d] = ctl_wr && wdata[OFS + B_STOP];
    assign clr[d]  = cnt_wr;

    always_ff @(posedge clk) begin
      if (rst) begin
        base[d] <= '0;
        cnt[d]  <= '0;
        ctl[d]  <= '{en: 1'b0, reload: 1'b0, mode: ALN_NONE};
      end else begin
        if (base_wr) base[d] <= {wdata[AW-1:2], 2'b00};
        if (cnt_wr)  cnt[d]  <= {wdata[CW-1:2], 2'b00};
        if (ctl_wr) begin
          ctl[d].en     <= wdata[OFS + B_EN] & ~wdata[OFS + B_STOP];
          ctl[d].reload <= wdata[OFS + B_RELOAD];
          ctl[d].mode   <= align_e'(wdata[OFS + B_MODE +: 2]);
        end else if (done[d]) begin
          ctl[d].en <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    ctrl_rd = '0;
    for (int d = 0; d < 2; d++) begin
      ctrl_rd[d*DIR_STRIDE + B_EN]        = ctl[d].en;
      ctrl_rd[d*DIR_STRIDE + B_RELOAD]    = ctl[d].reload;
      ctrl_rd[d*DIR_STRIDE + B_MODE +: 2] = ctl[d].mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= '0;
      if (aligned) begin
        case (idx)
          IX_TX_BASE: rdata <= 32'(base[0]);
          IX_RX_BASE: rdata <= 32'(base[1]);
          IX_TX_CNT:  rdata <= 32'(cnt[0]);
          IX_RX_CNT:  rdata <= 32'(cnt[1]);
          IX_CTRL:    rdata <= ctrl_rd;
          IX_TX_PROG: rdata <= 32'(prog[0]);
          IX_RX_PROG: rdata <= 32'(prog[1]);
          default:    rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/ardma_engine.sv
module ardma_engine
  import ardma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 26,
  parameter bit IS_RX = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          reload,
  input  align_e        mode,
  input  logic          stop,
  input  logic          clr,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] cnt,
  input  logic          side_ok,
  input  logic          gnt,
  input  logic [31:0]   din,
  output logic          req,
  output logic [AW-1:0] addr,
  output logic [31:0]   dout,
  output logic          dstrobe,
  output logic [CW-1:0] prog,
  output logic          half,
  output logic          full,
  output logic          done
);

  logic          run;
  logic          take;
  logic          last;
  logic [CW-1:0] nxt;
  logic [CW-1:0] half_thr;

  assign half_thr = {1'b0, cnt[CW-1:3], 2'b00};
  assign run      = en && (cnt >= CW'(MIN_BYTES));
  assign req      = run && side_ok;
  assign take     = req && gnt && !stop;
  assign nxt      = prog + CW'(4);
  assign last     = take && (nxt == cnt);
  assign done     = last && !reload;
  assign addr     = base + AW'(prog);

  always_ff @(posedge clk) begin
    if (rst) begin
      prog <= '0;
      half <= 1'b0;
      full <= 1'b0;
    end else begin
      half <= take && (nxt == half_thr);
      full <= last;
      if (stop || clr)  prog <= '0;
      else if (last)    prog <= '0;
      else if (take)    prog <= nxt;
    end
  end

  if (IS_RX) begin : g_rx
    assign dout    = align_word(mode, din);
    assign dstrobe = take;
  end else begin : g_tx
    always_ff @(posedge clk) begin
      if (rst) begin
        dout    <= '0;
        dstrobe <= 1'b0;
      end else begin
        dstrobe <= take;
        if (take) dout <= align_word(mode, din);
      end
    end
  end

endmodule

// File: rtl/audio_ring_dma.sv
module audio_ring_dma
  import ardma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 26
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          txm_req,
  output logic [AW-1:0] txm_addr,
  input  logic          txm_gnt,
  input  logic [31:0]   txm_rdata,
  output logic [31:0]   txs_data,
  output logic          txs_valid,
  input  logic          txs_full,
  input  logic [31:0]   rxs_data,
  input  logic          rxs_empty,
  output logic          rxs_pop,
  output logic          rxm_req,
  output logic [AW-1:0] rxm_addr,
  output logic [31:0]   rxm_wdata,
  input  logic          rxm_gnt,
  output logic [3:0]    evt
);

  dir_ctl_t      ctl     [2];
  logic          stop_a  [2];
  logic          clr_a   [2];
  logic [AW-1:0] base_a  [2];
  logic [CW-1:0] cnt_a   [2];
  logic [CW-1:0] prog_a  [2];
  logic          done_a  [2];
  logic          side_a  [2];
  logic          gnt_a   [2];
  logic [31:0]   din_a   [2];
  logic          req_a   [2];
  logic [AW-1:0] addr_a  [2];
  logic [31:0]   dout_a  [2];
  logic          stb_a   [2];
  logic          half_a  [2];
  logic          full_a  [2];

  logic          tx_en, rx_en;
  logic [CW-1:0] tx_prog, rx_prog, tx_cnt, rx_cnt;

  ardma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .rd    (reg_rd),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .prog  (prog_a),
    .done  (done_a),
    .ctl   (ctl),
    .stop  (stop_a),
    .clr   (clr_a),
    .base  (base_a),
    .cnt   (cnt_a)
  );

  assign side_a[0] = !txs_full;
  assign side_a[1] = !rxs_empty;
  assign gnt_a[0]  = txm_gnt;
  assign gnt_a[1]  = rxm_gnt;
  assign din_a[0]  = txm_rdata;
  assign din_a[1]  = rxs_data;

  for (genvar d = 0; d < 2; d++) begin : g_eng
    ardma_engine #(.AW(AW), .CW(CW), .IS_RX(d == 1)) u_eng (
      .clk     (clk),
      .rst     (rst),
      .en      (ctl[d].en),
      .reload  (ctl[d].reload),
      .mode    (ctl[d].mode),
      .stop    (stop_a[d]),
      .clr     (clr_a[d]),
      .base    (base_a[d]),
      .cnt     (cnt_a[d]),
      .side_ok (side_a[d]),
      .gnt     (gnt_a[d]),
      .din     (din_a[d]),
      .req     (req_a[d]),
      .addr    (addr_a[d]),
      .dout    (dout_a[d]),
      .dstrobe (stb_a[d]),
      .prog    (prog_a[d]),
      .half    (half_a[d]),
      .full    (full_a[d]),
      .done    (done_a[d])
    );
  end

  assign txm_req   = req_a[0];
  assign txm_addr  = addr_a[0];
  assign txs_data  = dout_a[0];
  assign txs_valid = stb_a[0];
  assign rxm_req   = req_a[1];
  assign rxm_addr  = addr_a[1];
  assign rxm_wdata = dout_a[1];
  assign rxs_pop   = stb_a[1];
  assign evt       = {full_a[1], half_a[1], full_a[0], half_a[0]};

  assign tx_en   = ctl[0].en;
  assign rx_en   = ctl[1].en;
  assign tx_prog = prog_a[0];
  assign rx_prog = prog_a[1];
  assign tx_cnt  = cnt_a[0];
  assign rx_cnt  = cnt_a[1];

endmodule

// File: rtl/ardma_checker.sv
module ardma_checker #(
  parameter int CW = 26
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_rd,
  input logic [2:0]    reg_idx,
  input logic [31:0]   reg_rdata,
  input logic          tx_stop,
  input logic          txm_req,
  input logic          txm_gnt,
  input logic          rxm_req,
  input logic [3:0]    evt,
  input logic          tx_en,
  input logic          rx_en,
  input logic [CW-1:0] tx_prog,
  input logic [CW-1:0] rx_prog,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);

  p_stop_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd && reg_idx == 3'd4) |-> (reg_rdata[1] == 1'b0 && reg_rdata[17] == 1'b0));

  p_tx_idle_no_req_r4: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> !txm_req);

  p_rx_idle_no_req_r4: assert property (@(posedge clk) disable iff (rst)
    !rx_en |-> !rxm_req);

  p_tx_half_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    evt[0] |=> !evt[0]);

  p_rx_half_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    evt[2] |=> !evt[2]);

  p_tx_full_wraps_r7: assert property (@(posedge clk) disable iff (rst)
    evt[1] |-> (tx_prog == '0));

  p_rx_full_wraps_r7: assert property (@(posedge clk) disable iff (rst)
    evt[3] |-> (rx_prog == '0));

  p_tx_full_after_grant_r7: assert property (@(posedge clk) disable iff (rst)
    evt[1] |-> $past(txm_req && txm_gnt));

  p_tx_stop_clears_r8: assert property (@(posedge clk) disable iff (rst)
    tx_stop |=> (tx_prog == '0 && !tx_en));

  p_tx_small_no_req_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt < CW'(8)) |-> !txm_req);

  p_tx_prog_bound_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt >= CW'(8)) |-> (tx_prog < tx_cnt));

  p_rx_prog_bound_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt >= CW'(8)) |-> (rx_prog < rx_cnt));

endmodule

bind audio_ring_dma ardma_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_rd    (reg_rd && reg_addr[1:0] == 2'b00),
  .reg_idx   (reg_addr[4:2]),
  .reg_rdata (reg_rdata),
  .tx_stop   (stop_a[0]),
  .txm_req   (txm_req),
  .txm_gnt   (txm_gnt),
  .rxm_req   (rxm_req),
  .evt       (evt),
  .tx_en     (tx_en),
  .rx_en     (rx_en),
  .tx_prog   (tx_prog),
  .rx_prog   (rx_prog),
  .tx_cnt    (tx_cnt),
  .rx_cnt    (rx_cnt)
);

// File: tb/audio_ring_dma_bench.sv
module audio_ring_dma_bench;

  localparam int AW = 32;
  localparam logic [31:0] MKEY = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        txm_req, txm_gnt, rxm_req, rxm_gnt;
  logic [AW-1:0] txm_addr, rxm_addr;
  logic [31:0] txm_rdata, txs_data, rxs_data, rxm_wdata;
  logic        txs_valid, txs_full = 1'b0, rxs_empty = 1'b1, rxs_pop;
  logic [3:0]  evt;
  logic        tx_gnt_en = 1'b1, rx_gnt_en = 1'b0;

  int n_chk = 0, n_fail = 0;
  int tx_push_n = 0, tx_half_n = 0, tx_full_n = 0, tx_half_at = 0, tx_req_n = 0;
  int rx_half_n = 0, rx_full_n = 0, rx_wr_n = 0, rx_pop_n = 0;
  logic [31:0] tx_last = '0, rx_last_addr = '0, rx_last_data = '0;

  always #5 clk = ~clk;

  assign txm_gnt   = txm_req & tx_gnt_en;
  assign txm_rdata = txm_addr ^ MKEY;
  assign rxm_gnt   = rxm_req & rx_gnt_en;
  assign rxs_data  = 32'hC0DE_0000 + 32'(rx_pop_n);

  audio_ring_dma #(.AW(AW), .CW(26)) u_audio_ring_dma (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txm_req(txm_req), .txm_addr(txm_addr),
    .txm_gnt(txm_gnt), .txm_rdata(txm_rdata), .txs_data(txs_data), .txs_valid(txs_valid),
    .txs_full(txs_full), .rxs_data(rxs_data), .rxs_empty(rxs_empty), .rxs_pop(rxs_pop),
    .rxm_req(rxm_req), .rxm_addr(rxm_addr), .rxm_wdata(rxm_wdata), .rxm_gnt(rxm_gnt), .evt(evt)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (txs_valid) begin tx_push_n <= tx_push_n + 1; tx_last <= txs_data; end
      if (evt[0]) begin tx_half_n <= tx_half_n + 1; tx_half_at <= tx_push_n + 1; end
      if (evt[1]) tx_full_n <= tx_full_n + 1;
      if (evt[2]) rx_half_n <= rx_half_n + 1;
      if (evt[3]) rx_full_n <= rx_full_n + 1;
      if (txm_req) tx_req_n <= tx_req_n + 1;
      if (rxs_pop) rx_pop_n <= rx_pop_n + 1;
      if (rxm_req && rxm_gnt) begin
        rx_wr_n <= rx_wr_n + 1; rx_last_addr <= rxm_addr; rx_last_data <= rxm_wdata;
      end
    end
  end

  function automatic logic [31:0] brev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] hswap(input logic [31:0] w);
    return {w[15:0], w[31:16]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 7; i++) begin
      rd(5'(i * 4), v);
      chk("R1 register reset value", v, 32'h0);
    end
    chk("R1 events idle", {28'h0, evt}, 32'h0);
    chk("R1 no requests", {30'h0, txm_req, rxm_req}, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, v);
    chk("R2 count clipped to 0x03FFFFFC", v, 32'h03FF_FFFC);
    wr(5'h04, 32'h0000_1237); rd(5'h04, v);
    chk("R2 address low bits read 0", v, 32'h0000_1234);
    wr(5'h06, 32'h0000_0055); rd(5'h04, v);
    chk("R2 misaligned write ignored", v, 32'h0000_1234);
    wr(5'h10, 32'h0206_0206); rd(5'h10, v);
    chk("R3 control readback, stop bits read 0", v, 32'h0204_0204);
    rd(5'h14, v);
    chk("R8 stop bits cleared progress", v, 32'h0);
    wr(5'h10, 32'h0); wr(5'h04, 32'h0); wr(5'h08, 32'h0);
  endtask

  task automatic t_oneshot(input logic [31:0] base, input logic [31:0] cnt, input int exp_half);
    logic [31:0] v;
    int p0, h0, f0;
    wr(5'h00, base); wr(5'h08, cnt);
    p0 = tx_push_n; h0 = tx_half_n; f0 = tx_full_n;
    wr(5'h10, 32'h1);
    idle(20);
    chk("R4 words pushed in one pass", 32'(tx_push_n - p0), cnt / 4);
    chk("R4 last word from last address", tx_last, (base + cnt - 4) ^ MKEY);
    chk("R6 one half event", 32'(tx_half_n - h0), 32'd1);
    chk("R6 half event after count/2 rounded down", 32'(tx_half_at - p0), 32'(exp_half));
    chk("R7 one full event", 32'(tx_full_n - f0), 32'd1);
    rd(5'h10, v);
    chk("R7 enable cleared without reload", v & 32'h1, 32'h0);
    rd(5'h14, v);
    chk("R7 progress back to 0", v, 32'h0);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    int p0, h0, f0, n;
    wr(5'h00, 32'h300); wr(5'h08, 32'h8);
    p0 = tx_push_n; h0 = tx_half_n; f0 = tx_full_n;
    tx_gnt_en = 1'b1;
    wr(5'h10, 32'h0000_0105);
    while (tx_full_n - f0 < 3) @(negedge clk);
    tx_gnt_en = 1'b0;
    idle(3);
    n = tx_push_n - p0;
    chk("R7 reload keeps running past three passes", 32'(n >= 6), 32'h1);
    chk("R5 byte-reversed data at wrapped address", tx_last, brev((32'h300 + 32'(4 * ((n - 1) % 2))) ^ MKEY));
    chk("R7 full events per pass", 32'(tx_full_n - f0), 32'(n / 2));
    chk("R6 half events per pass", 32'(tx_half_n - h0), 32'((n + 1) / 2));
    wr(5'h08, 32'h40); rd(5'h08, v);
    chk("R10 count write ignored while enabled", v, 32'h8);
    wr(5'h10, 32'h0000_0102);
    rd(5'h10, v);
    chk("R8 force stop clears enable", v & 32'h1, 32'h0);
    rd(5'h14, v);
    chk("R8 force stop clears progress", v, 32'h0);
    tx_gnt_en = 1'b1;
  endtask

  task automatic t_small_count;
    int r0, p0;
    wr(5'h08, 32'h4);
    r0 = tx_req_n; p0 = tx_push_n;
    wr(5'h10, 32'h1);
    idle(10);
    chk("R9 no request with count below 8", 32'(tx_req_n - r0), 32'h0);
    chk("R9 no push with count below 8", 32'(tx_push_n - p0), 32'h0);
    wr(5'h10, 32'h0);
  endtask

  task automatic t_rx_pause;
    logic [31:0] v;
    int w0;
    wr(5'h04, 32'h200); wr(5'h0C, 32'h10);
    rxs_empty = 1'b0; rx_gnt_en = 1'b0; w0 = rx_wr_n;
    wr(5'h10, 32'h0201_0000);
    rx_gnt_en = 1'b1;
    @(negedge clk); @(negedge clk);
    rx_gnt_en = 1'b0;
    chk("R4 two words written", 32'(rx_wr_n - w0), 32'd2);
    chk("R4 receive address is start plus progress", rx_last_addr, 32'h204);
    chk("R5 halves swapped on receive", rx_last_data, hswap(32'hC0DE_0001));
    wr(5'h10, 32'h0200_0000);
    rd(5'h18, v);
    chk("R8 pause keeps receive progress", v, 32'h8);
    rx_gnt_en = 1'b1;
    idle(5);
    chk("R8 paused engine writes nothing", 32'(rx_wr_n - w0), 32'd2);
    wr(5'h10, 32'h0201_0000);
    idle(10);
    chk("R8 resume completes pass", 32'(rx_wr_n - w0), 32'd4);
    chk("R4 resumed address continues", rx_last_addr, 32'h20C);
    chk("R6 receive half event once", 32'(rx_half_n), 32'd1);
    chk("R7 receive full event once", 32'(rx_full_n), 32'd1);
    rd(5'h10, v);
    chk("R7 receive enable cleared", v & 32'h0001_0000, 32'h0);
    rxs_empty = 1'b1;
  endtask

  task automatic t_stop_vs_grant;
    logic [31:0] v;
    int p0, h0, f0;
    wr(5'h00, 32'h500); wr(5'h08, 32'h8);
    p0 = tx_push_n; h0 = tx_half_n; f0 = tx_full_n;
    tx_gnt_en = 1'b1;
    @(negedge clk); reg_wr = 1'b1; reg_addr = 5'h10; reg_wdata = 32'h1;
    @(negedge clk); reg_wr = 1'b0;
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'h2;
    @(negedge clk); reg_wr = 1'b0;
    idle(4);
    chk("R11 only first word pushed", 32'(tx_push_n - p0), 32'd1);
    chk("R11 half event from first word", 32'(tx_half_n - h0), 32'd1);
    chk("R11 no full event when stop wins", 32'(tx_full_n - f0), 32'd0);
    rd(5'h14, v);
    chk("R11 progress cleared by stop", v, 32'h0);
    rd(5'h10, v);
    chk("R11 enable cleared by stop", v & 32'h1, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_regmap();
    t_oneshot(32'h100, 32'h10, 2);
    t_oneshot(32'h180, 32'h0C, 1);
    t_reload();
    t_small_count();
    t_rx_pause();
    t_stop_vs_grant();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule